// File: doc/BRIEF.md
# Timer Event and Wakeup Controller

This block sits next to a free-running timer counter and its prescaler chain. Each cycle it takes three condition inputs: a counter overflow pulse, an alarm-match pulse, and the prescaler value together with a bit select. From these it produces a registered, per-source peripheral event output and a latched wakeup request toward a sleep controller. The periodic source is found inside the block as a rising edge of the chosen prescaler stage.

Software programs the block through a small write-only register port with four addresses. Two of them set and clear the event mask one bit at a time. One loads the wake enable register. The last clears latched wake status bits. Wake gating does not depend on the event mask or on any interrupt mask. A latched wake stays high until software clears it. The sleep controller is modelled as a sleep-request strobe and an `asleep` flag: the flag drops once a wake is pending, and a sleep request made while a wake is pending never takes effect.

Top module: `tmr_wake_ctl`

## Requirements
- R1: After reset, `evtOut`, `wakeStatus`, `wakeReq` and `asleep` are zero. The event mask and the wake enable register are also zero, so a source pulse right after reset produces neither an event nor a wake.
- R2: Source bits are ordered bit 0 overflow, bit 1 alarm match, bit 2 periodic edge. `evtOut[i]` is high in the cycle after a cycle in which source i was active and mask bit i was one. Otherwise it is zero.
- R3: A write to address 0 sets every mask bit whose data bit is one. A mask change takes effect for sources in the cycle after the write. Data bits that are zero leave the mask unchanged.
- R4: A write to address 1 clears every mask bit whose data bit is one. Data bits that are zero leave the mask unchanged.
- R5: The periodic source is active in a cycle when `prescVal[prescSel]` is one and was zero in the previous cycle, with the previous value taken as zero right after reset. A bit that stays high produces only one event.
- R6: A write to address 2 loads the wake enable register from the data. `wakeStatus[i]` becomes one in the cycle after source i is active while wake enable bit i is one. The event mask has no influence on this.
- R7: A latched `wakeStatus` bit stays one until a write to address 3 has a one in that bit position. Zero data bits at address 3 leave the status unchanged.
- R8: If a source sets a wake status bit in the same cycle that an address-3 write clears it, the bit ends up one.
- R9: `wakeReq` is high exactly when any `wakeStatus` bit is one.
- R10: `asleep` rises in the cycle after `sleepReq` when `wakeReq` is low. It falls in the cycle after `wakeReq` is high. When `sleepReq` arrives while `wakeReq` is high, `asleep` stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ovfPulse | input | 1 | Counter overflow pulse |
| alarmHit | input | 1 | Counter equals alarm value |
| prescVal | input | PRESC_W | Prescaler stage values |
| prescSel | input | SEL_W | Index of the periodic prescaler stage (5 bits by default) |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 mask set, 1 mask clear, 2 wake enable, 3 wake clear |
| regData | input | 3 | Register write data, one bit per source |
| sleepReq | input | 1 | Sleep request strobe |
| evtOut | output | 3 | Per-source peripheral event pulses |
| wakeStatus | output | 3 | Latched wake status per source |
| wakeReq | output | 1 | Wake request to the sleep controller |
| asleep | output | 1 | Modelled sleep state |

## Verification
Two things can land on the same wake bit in one cycle: a source that sets it and a software clear. The bench provokes this by pulsing overflow together with an address-3 write of bit 0. It expects the bit to stay set both when the bit was already latched and when it was clear. A second collision is a sleep request that arrives while a wake is still latched, and the bench requires `asleep` to stay low afterwards. A behavioural model compares every output on every clock, across directed steps and a long random run in which writes, pulses and select changes overlap freely.

// File: rtl/tmr_wake_pkg.sv
package tmr_wake_pkg;

  localparam int NSRC   = 3;
  localparam int ADDR_W = 2;

  localparam int SRC_OVF = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;

  localparam logic [ADDR_W-1:0] A_EV_SET  = 2'd0;
  localparam logic [ADDR_W-1:0] A_EV_CLR  = 2'd1;
  localparam logic [ADDR_W-1:0] A_WAKE_EN = 2'd2;
  localparam logic [ADDR_W-1:0] A_WAKE_CL = 2'd3;

  typedef struct packed {
    logic [NSRC-1:0] evSet;
    logic [NSRC-1:0] evClr;
    logic            wenLoad;
    logic [NSRC-1:0] wenData;
    logic [NSRC-1:0] wkClr;
  } ctlStb_t;

endpackage

// File: rtl/tmr_wake_regdec.sv
module tmr_wake_regdec
  import tmr_wake_pkg::*;
(
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NSRC-1:0]   regData,
  output ctlStb_t           stb
);

  always_comb begin
    stb = '0;
    if (regWr) begin
      unique case (regAddr)
        A_EV_SET:  stb.evSet = regData;
        A_EV_CLR:  stb.evClr = regData;
        A_WAKE_EN: begin
          stb.wenLoad = 1'b1;
          stb.wenData = regData;
        end
        A_WAKE_CL: stb.wkClr = regData;
        default:   stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmr_wake_core.sv
module tmr_wake_core
  import tmr_wake_pkg::*;
#(
  parameter int PRESC_W = 32,
  parameter int SEL_W   = $clog2(PRESC_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ovfPulse,
  input  logic               alarmHit,
  input  logic [PRESC_W-1:0] prescVal,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic               sleepReq,
  input  ctlStb_t            stb,
  output logic [NSRC-1:0]    evtOut,
  output logic [NSRC-1:0]    wakeStatus,
  output logic               wakeReq,
  output logic               asleep
);

  logic            selBit;
  logic            selBitDly;
  logic            perEdge;
  logic [NSRC-1:0] srcVec;
  logic [NSRC-1:0] evMask;
  logic [NSRC-1:0] wakeEn;

  // periodic source: rising edge of the chosen prescaler stage
  assign selBit  = prescVal[prescSel];
  assign perEdge = selBit & ~selBitDly;

  always_ff @(posedge clk) begin
    if (!rstN) selBitDly <= 1'b0;
    else       selBitDly <= selBit;
  end

  always_comb begin
    srcVec          = '0;
    srcVec[SRC_OVF] = ovfPulse;
    srcVec[SRC_ALM] = alarmHit;
    srcVec[SRC_PER] = perEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            wakeEn <= '0;
    else if (stb.wenLoad) wakeEn <= stb.wenData;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // event mask bit: set and clear come from different addresses
    always_ff @(posedge clk) begin
      if (!rstN)              evMask[i] <= 1'b0;
      else if (stb.evSet[i])  evMask[i] <= 1'b1;
      else if (stb.evClr[i])  evMask[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) evtOut[i] <= 1'b0;
      else       evtOut[i] <= srcVec[i] & evMask[i];
    end

    // wake status: a new set beats a software clear
    always_ff @(posedge clk) begin
      if (!rstN)                       wakeStatus[i] <= 1'b0;
      else if (srcVec[i] & wakeEn[i])  wakeStatus[i] <= 1'b1;
      else if (stb.wkClr[i])           wakeStatus[i] <= 1'b0;
    end
  end

  assign wakeReq = |wakeStatus;

  always_ff @(posedge clk) begin
    if (!rstN)         asleep <= 1'b0;
    else if (wakeReq)  asleep <= 1'b0;
    else if (sleepReq) asleep <= 1'b1;
  end

endmodule

// File: rtl/tmr_wake_ctl.sv
module tmr_wake_ctl
  import tmr_wake_pkg::*;
#(
  parameter int PRESC_W = 32,
  localparam int SEL_W  = $clog2(PRESC_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ovfPulse,
  input  logic               alarmHit,
  input  logic [PRESC_W-1:0] prescVal,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [2:0]         regData,
  input  logic               sleepReq,
  output logic [2:0]         evtOut,
  output logic [2:0]         wakeStatus,
  output logic               wakeReq,
  output logic               asleep
);

  ctlStb_t ctlStb;

  tmr_wake_regdec u_dec (
    .regWr   (regWr),
    .regAddr (regAddr),
    .regData (regData),
    .stb     (ctlStb)
  );

  tmr_wake_core #(
    .PRESC_W (PRESC_W),
    .SEL_W   (SEL_W)
  ) u_core (
    .clk        (clk),
    .rstN       (rstN),
    .ovfPulse   (ovfPulse),
    .alarmHit   (alarmHit),
    .prescVal   (prescVal),
    .prescSel   (prescSel),
    .sleepReq   (sleepReq),
    .stb        (ctlStb),
    .evtOut     (evtOut),
    .wakeStatus (wakeStatus),
    .wakeReq    (wakeReq),
    .asleep     (asleep)
  );

endmodule

// File: rtl/tmr_wake_chk.sv
module tmr_wake_chk
  import tmr_wake_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      ovfPulse,
  input logic      alarmHit,
  input ctlStb_t   ctlStb,
  input logic [2:0] evtOut,
  input logic [2:0] wakeStatus,
  input logic      wakeReq,
  input logic      asleep
);

  // R2: an overflow or alarm event needs the source one cycle earlier
  p_evt_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((!evtOut[0] || $past(ovfPulse)) && (!evtOut[1] || $past(alarmHit))));

  // R4: a mask bit cleared two cycles ago cannot yield an event now
  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.evClr[0] |=> 1'b1 ##1 !evtOut[0]);

  // R5: the periodic edge cannot fire on two consecutive cycles
  p_edge_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtOut[2] |=> !evtOut[2]);

  // R6: a new overflow wake bit follows an overflow pulse
  p_wake_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wakeStatus[0] ##1 wakeStatus[0] |-> $past(ovfPulse));

  // R7: latched status bits persist unless cleared
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(wakeStatus) & ~$past(ctlStb.wkClr) & ~wakeStatus) == 3'b000));

  // R10: a pending wake forces the sleep flag low next cycle
  p_no_sleep_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |=> !asleep);

endmodule

bind tmr_wake_ctl tmr_wake_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ovfPulse   (ovfPulse),
  .alarmHit   (alarmHit),
  .ctlStb     (ctlStb),
  .evtOut     (evtOut),
  .wakeStatus (wakeStatus),
  .wakeReq    (wakeReq),
  .asleep     (asleep)
);

// File: tb/sim_tmr_wake_ctl.sv
module sim_tmr_wake_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ovfPulse = 1'b0, alarmHit = 1'b0, regWr = 1'b0, sleepReq = 1'b0;
  logic [PW-1:0] prescVal = '0;
  logic [4:0]    prescSel = 5'd4;
  logic [1:0]    regAddr = 2'd0;
  logic [2:0]    regData = 3'd0;
  logic [2:0]    evtOut, wakeStatus;
  logic          wakeReq, asleep;

  // stimulus staging
  logic          dOvf = 0, dAlm = 0, dWr = 0, dSlp = 0;
  logic [PW-1:0] dPresc = '0;
  logic [4:0]    dSel = 5'd4;
  logic [1:0]    dAddr = 0;
  logic [2:0]    dData = 0;

  // reference model state
  logic [2:0] mMask = 0, mWen = 0, mStat = 0, mEvt = 0;
  logic       mSleep = 0, mPrev = 0;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wake_ctl #(.PRESC_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .ovfPulse(ovfPulse), .alarmHit(alarmHit),
    .prescVal(prescVal), .prescSel(prescSel), .regWr(regWr),
    .regAddr(regAddr), .regData(regData), .sleepReq(sleepReq),
    .evtOut(evtOut), .wakeStatus(wakeStatus), .wakeReq(wakeReq), .asleep(asleep)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check(evtOut == mEvt, "R2 evtOut", evtOut, mEvt);
    check(wakeStatus == mStat, "R7 wakeStatus", wakeStatus, mStat);
    check(wakeReq == (mStat != 0), "R9 wakeReq", wakeReq, mStat != 0);
    check(asleep == mSleep, "R10 asleep", asleep, mSleep);
  endtask

  task automatic modelStep();
    logic       curBit;
    logic [2:0] src, clrV, nStat;
    curBit = dPresc[dSel];
    src    = {curBit & ~mPrev, dAlm, dOvf};
    mEvt   = src & mMask;
    clrV   = (dWr && dAddr == 2'd3) ? dData : 3'b000;
    nStat  = (mStat & ~clrV) | (src & mWen);
    if (mStat != 0) mSleep = 0;
    else if (dSlp)  mSleep = 1;
    mStat = nStat;
    if (dWr && dAddr == 2'd0) mMask = mMask | dData;
    if (dWr && dAddr == 2'd1) mMask = mMask & ~dData;
    if (dWr && dAddr == 2'd2) mWen = dData;
    mPrev = curBit;
  endtask

  // one clock: drive at negedge, model at posedge, compare just after
  task automatic tick();
    @(negedge clk);
    ovfPulse = dOvf; alarmHit = dAlm; prescVal = dPresc; prescSel = dSel;
    regWr = dWr; regAddr = dAddr; regData = dData; sleepReq = dSlp;
    @(posedge clk);
    modelStep();
    #1;
    compareAll();
    dOvf = 0; dAlm = 0; dWr = 0; dSlp = 0; dPresc = '0; dAddr = 0; dData = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    dWr = 1; dAddr = a; dData = d;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(evtOut == 0 && wakeStatus == 0 && !wakeReq && !asleep, "R1 reset outputs",
          {evtOut, wakeStatus, wakeReq, asleep}, 0);

    dOvf = 1; tick();
    check(evtOut == 3'b000, "R1 mask zero after reset", evtOut, 0);
    check(wakeStatus == 3'b000, "R1 wake enable zero after reset", wakeStatus, 0);

    wr(2'd0, 3'b001);
    dOvf = 1; dAlm = 1; tick();
    check(evtOut == 3'b001, "R3 set overflow mask", evtOut, 3'b001);
    wr(2'd0, 3'b000);
    dOvf = 1; tick();
    check(evtOut == 3'b001, "R3 zero bits keep mask", evtOut, 3'b001);
    wr(2'd0, 3'b110);
    dOvf = 1; dAlm = 1; tick();
    check(evtOut == 3'b011, "R3 set alarm and periodic", evtOut, 3'b011);

    wr(2'd1, 3'b010);
    dOvf = 1; dAlm = 1; tick();
    check(evtOut == 3'b001, "R4 clear alarm mask", evtOut, 3'b001);
    wr(2'd1, 3'b000);
    dOvf = 1; tick();
    check(evtOut == 3'b001, "R4 zero bits keep mask", evtOut, 3'b001);

    dSel = 5'd4;
    tick();
    dPresc = 32'h10; tick();
    check(evtOut == 3'b100, "R5 rising edge of stage 4", evtOut, 3'b100);
    dPresc = 32'h10; tick();
    check(evtOut == 3'b000, "R5 held stage gives no event", evtOut, 0);
    tick();

    wr(2'd2, 3'b101);
    wr(2'd1, 3'b111);
    dOvf = 1; tick();
    check(wakeStatus == 3'b001 && evtOut == 3'b000, "R6 wake without event mask",
          {evtOut, wakeStatus}, 3'b001);
    dAlm = 1; tick();
    check(wakeStatus == 3'b001, "R6 disabled alarm does not wake", wakeStatus, 3'b001);

    dSlp = 1; tick();
    check(asleep == 1'b0, "R10 sleep with pending wake ends at once", asleep, 0);

    wr(2'd3, 3'b000);
    check(wakeStatus == 3'b001, "R7 zero bits keep status", wakeStatus, 3'b001);
    dOvf = 1; wr(2'd3, 3'b001);
    check(wakeStatus == 3'b001, "R8 set wins over clear (latched)", wakeStatus, 3'b001);
    wr(2'd3, 3'b001);
    check(wakeStatus == 3'b000, "R7 clear by write one", wakeStatus, 0);
    dOvf = 1; wr(2'd3, 3'b001);
    check(wakeStatus == 3'b001, "R8 set wins over clear (idle)", wakeStatus, 3'b001);
    wr(2'd3, 3'b111);

    dSlp = 1; tick();
    check(asleep == 1'b1, "R10 sleep entered", asleep, 1);
    tick();
    dPresc = 32'h10; tick();
    check(wakeStatus == 3'b100 && asleep == 1'b1, "R6 periodic wake latched",
          {wakeStatus, asleep}, 4'b1001);
    tick();
    check(asleep == 1'b0 && wakeReq == 1'b1, "R9 wake ends sleep", {asleep, wakeReq}, 1);

    // random traffic with overlapping writes, pulses and select changes
    for (int k = 0; k < 2000; k++) begin
      dOvf   = ($urandom_range(0, 7) == 0);
      dAlm   = ($urandom_range(0, 7) == 0);
      dPresc = k;
      if ($urandom_range(0, 63) == 0) dSel = 5'($urandom_range(0, 6));
      dWr    = ($urandom_range(0, 3) == 0);
      dAddr  = 2'($urandom_range(0, 3));
      dData  = 3'($urandom_range(0, 7));
      dSlp   = ($urandom_range(0, 9) == 0);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

endmodule